// File: doc/BRIEF.md
# Multi-Channel Reloadable Down-Counter Timer

This block holds two or three independent timer channels behind a small register bus. Each channel has a down-counter, a reload value and a control register. The control register selects a prescale ratio, holds an underflow flag and holds an interrupt enable. Every channel's prescaler divides the block clock.

A single shared start register has one run bit per channel. Software changes it by reading it, modifying it and writing it back. When a running channel's counter is already zero and a prescaled tick arrives, the counter is refilled from its reload value and the sticky underflow flag is set. The flag raises the channel's interrupt line while the enable bit is on. Software clears the flag by writing the control register with the flag bit at 0.

A layout parameter chooses between two address maps. In the default map the start register is at byte address 4 and channel n begins at 8 + 12n. In the alternate map the start register is at 2 and channel n begins at 4 + 12n. Inside a channel the reload value is at +0, the counter at +4 and the control register at +8. Reads are combinational on the address. A write takes effect at the clock edge where `bus_we` is high. Unmapped addresses read as zero and ignore writes.

Top module: `tmr_unit`

## Requirements
- R1: After reset the start register reads 0, every counter and reload register reads 0xFFFFFFFF, every control register reads 0 and every interrupt output is low.
- R2: In the default map the start register is at byte 4 and channel n's reload, counter and control registers are at 8+12n, 12+12n and 16+12n. With the alternate layout the start register is at 2 and channel n begins at 4+12n. Reload and counter registers read back the value written while their channel is stopped.
- R3: Bit n of the start register runs channel n. A write sets every bit to the written value, bits at or above the channel count read as 0, and a stopped channel's counter holds its value.
- R4: Control bits [2:0] select one count tick every 4, 16, 64, 256 or 1024 clocks for codes 0 to 4. Codes 5 to 7 act as 1024.
- R5: The counter decrements by one per count tick. A tick while the counter is 0 instead loads the reload value and sets the underflow flag (control bit 8).
- R6: Each interrupt output is high exactly while its channel's underflow flag and interrupt enable (control bit 5) are both 1. Clearing bit 5 keeps the flag and the prescale code.
- R7: A control write with bit 8 at 0 clears the flag, and a write with bit 8 at 1 leaves it unchanged. Control bits 15:9, 7:6 and 4:3 read as 0.
- R8: A channel's prescaler restarts when its run bit goes from 0 to 1. The first tick after a start therefore lands on the clock edge one full prescale period (4 edges for code 0) after the edge that wrote the run bit.
- R9: When an underflow and a control write that clears the flag fall on the same edge, the flag ends up set.
- R10: A counter write on the same edge as a count tick loads the written value, and that tick is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_we | input | 1 | Write strobe for the addressed register |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, zero-extended |
| irq | output | NUM_CH | Per-channel underflow interrupt |

## Verification
An underflow and a software write to the same channel can share one clock edge. Two cases matter: a control write that clears the flag, and a counter write. The bench counts edges from the start write and places each write exactly on the edge where the prescaled tick reaches a zero counter, or where any tick lands. It then checks that the flag stays set and that the written counter value wins over the tick. A near-exhaustive sweep over all eight prescale codes compares the counter, flag and interrupt line against an arithmetic model of the tick count.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
  localparam int PSC_W     = 10;
  localparam int UNIE_BIT  = 5;
  localparam int UNF_BIT   = 8;

  // terminal count of the prescaler for a 3-bit ratio code
  function automatic logic [PSC_W-1:0] psc_limit(input logic [2:0] code);
    case (code)
      3'd0:    psc_limit = PSC_W'(3);
      3'd1:    psc_limit = PSC_W'(15);
      3'd2:    psc_limit = PSC_W'(63);
      3'd3:    psc_limit = PSC_W'(255);
      default: psc_limit = PSC_W'(1023);
    endcase
  endfunction
endpackage

// File: rtl/tmr_prescaler.sv
`timescale 1ns/1ps
module tmr_prescaler
  import tmr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [2:0] code,
  output logic       tick
);
  logic [PSC_W-1:0] div_q, div_d;

  assign tick = run && (div_q >= psc_limit(code));

  always_comb begin
    if (!run || tick) div_d = '0;
    else              div_d = div_q + PSC_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  // R8
  psc_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !tick);
endmodule

// File: rtl/tmr_channel.sv
`timescale 1ns/1ps
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             rl_we,
  input  logic             cnt_we,
  input  logic             ctl_we,
  input  logic [31:0]      wdata,
  output logic [CNT_W-1:0] reload_o,
  output logic [CNT_W-1:0] count_o,
  output logic [15:0]      ctl_o,
  output logic             irq_o
);
  logic [CNT_W-1:0] reload_q, reload_d, cnt_q, cnt_d;
  logic [2:0]       psel_q, psel_d;
  logic             unie_q, unie_d, unf_q, unf_d;
  logic             tick, uflow;

  tmr_prescaler psc_i (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run),
    .code (psel_q),
    .tick (tick)
  );

  assign uflow = tick && (cnt_q == '0);

  always_comb begin
    reload_d = rl_we ? wdata[CNT_W-1:0] : reload_q;
    if (cnt_we)     cnt_d = wdata[CNT_W-1:0];
    else if (uflow) cnt_d = reload_q;
    else if (tick)  cnt_d = cnt_q - CNT_W'(1);
    else            cnt_d = cnt_q;
    psel_d = ctl_we ? wdata[2:0] : psel_q;
    unie_d = ctl_we ? wdata[UNIE_BIT] : unie_q;
    // software may only clear; a new underflow always wins
    unf_d  = (ctl_we ? (unf_q & wdata[UNF_BIT]) : unf_q) | uflow;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= '1;
      cnt_q    <= '1;
      psel_q   <= '0;
      unie_q   <= 1'b0;
      unf_q    <= 1'b0;
    end else begin
      reload_q <= reload_d;
      cnt_q    <= cnt_d;
      psel_q   <= psel_d;
      unie_q   <= unie_d;
      unf_q    <= unf_d;
    end
  end

  assign reload_o = reload_q;
  assign count_o  = cnt_q;
  assign ctl_o    = {7'b0, unf_q, 2'b0, unie_q, 2'b0, psel_q};
  assign irq_o    = unf_q & unie_q;

  // R3
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_we) |=> $stable(cnt_q));
  // R5
  uflow_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (uflow && !cnt_we) |=> (unf_q && cnt_q == $past(reload_q)));
  // R5
  unf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unf_q) |-> $past(uflow));
  // R7
  unf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && !unf_q && !uflow) |=> !unf_q);
  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (uflow && ctl_we) |=> unf_q);
endmodule

// File: rtl/tmr_unit.sv
`timescale 1ns/1ps
module tmr_unit #(
  parameter int NUM_CH     = 3,
  parameter int ALT_LAYOUT = 0,
  parameter int ADDR_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [NUM_CH-1:0] irq
);
  localparam int CNT_W     = 32;
  localparam int START_OFS = (ALT_LAYOUT != 0) ? 2 : 4;
  localparam int CH_BASE   = (ALT_LAYOUT != 0) ? 4 : 8;
  localparam int CH_STRIDE = 12;

  logic [1:0]        rs_q;
  logic              rst_i_n;
  logic [NUM_CH-1:0] run_q, run_d;
  logic              start_hit;
  logic [NUM_CH-1:0] hit_rl, hit_cnt, hit_ctl;
  logic [CNT_W-1:0]  reload_v [NUM_CH];
  logic [CNT_W-1:0]  count_v  [NUM_CH];
  logic [15:0]       ctl_v    [NUM_CH];

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  assign start_hit = (bus_addr == ADDR_W'(START_OFS));

  always_comb run_d = (bus_we && start_hit) ? bus_wdata[NUM_CH-1:0] : run_q;

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) run_q <= '0;
    else          run_q <= run_d;
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    assign hit_rl[i]  = (bus_addr == ADDR_W'(CH_BASE + CH_STRIDE*i));
    assign hit_cnt[i] = (bus_addr == ADDR_W'(CH_BASE + CH_STRIDE*i + 4));
    assign hit_ctl[i] = (bus_addr == ADDR_W'(CH_BASE + CH_STRIDE*i + 8));

    tmr_channel #(.CNT_W(CNT_W)) ch_i (
      .clk     (clk),
      .rst_n   (rst_i_n),
      .run     (run_q[i]),
      .rl_we   (bus_we && hit_rl[i]),
      .cnt_we  (bus_we && hit_cnt[i]),
      .ctl_we  (bus_we && hit_ctl[i]),
      .wdata   (bus_wdata),
      .reload_o(reload_v[i]),
      .count_o (count_v[i]),
      .ctl_o   (ctl_v[i]),
      .irq_o   (irq[i])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (start_hit) bus_rdata = 32'(run_q);
    for (int i = 0; i < NUM_CH; i++) begin
      if (hit_rl[i])  bus_rdata = reload_v[i];
      if (hit_cnt[i]) bus_rdata = count_v[i];
      if (hit_ctl[i]) bus_rdata = 32'(ctl_v[i]);
    end
  end

  // R3
  start_wr_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (bus_we && start_hit) |=> (run_q == $past(bus_wdata[NUM_CH-1:0])));
endmodule

// File: tb/tmr_unit_tb.sv
`timescale 1ns/1ps
module tmr_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0, alt_we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, alt_rdata;
  logic [2:0]  irq;
  logic [1:0]  alt_irq;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  tmr_unit #(.NUM_CH(3), .ALT_LAYOUT(0), .ADDR_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_we(we), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .irq(irq));

  tmr_unit #(.NUM_CH(2), .ALT_LAYOUT(1), .ADDR_W(8)) dut_alt (
    .clk(clk), .rst_n(rst_n), .bus_we(alt_we), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(alt_rdata), .irq(alt_irq));

  localparam logic [7:0] START = 8'd4;
  function automatic logic [7:0] ra(input int n, input int off);
    return 8'(8 + 12*n + off);
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(posedge clk); #1; we = 1'b0;
  endtask

  task automatic wr_alt(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; alt_we = 1'b1;
    @(posedge clk); #1; alt_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    addr = a; #1; v = rdata;
  endtask

  task automatic model(input logic [31:0] c0, input logic [31:0] r, input int t,
                       output logic [31:0] c, output logic uf);
    c = c0; uf = 1'b0;
    for (int k = 0; k < t; k++) begin
      if (c == 0) begin c = r; uf = 1'b1; end
      else c = c - 1;
    end
  endtask

  initial begin
    #800000;
    bad++; total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v, ec;
    logic euf;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1 reset state
    rd(START, v); chk("R1", "start", v, 0);
    for (int n = 0; n < 3; n++) begin
      rd(ra(n,0), v); chk("R1", "reload", v, 32'hFFFFFFFF);
      rd(ra(n,4), v); chk("R1", "count", v, 32'hFFFFFFFF);
      rd(ra(n,8), v); chk("R1", "ctrl", v, 0);
    end
    chk("R1", "irq", 32'(irq), 0);

    // R2 address map, stopped writes read back
    for (int n = 0; n < 3; n++) begin
      wr(ra(n,0), 32'h10000000 + 32'(n*273));
      wr(ra(n,4), 32'h20000000 + 32'(n));
    end
    for (int n = 0; n < 3; n++) begin
      rd(ra(n,0), v); chk("R2", "reload", v, 32'h10000000 + 32'(n*273));
      rd(ra(n,4), v); chk("R2", "count", v, 32'h20000000 + 32'(n));
    end
    rd(8'd200, v); chk("R2", "unmapped", v, 0);
    wr_alt(8'd16, 32'hA5A5_0001);
    addr = 8'd16; #1; chk("R2", "alt ch1 reload", alt_rdata, 32'hA5A5_0001);
    wr_alt(8'd2, 32'hFF);
    addr = 8'd2; #1; chk("R2", "alt start", alt_rdata, 32'h3);
    wr_alt(8'd2, 32'h0);

    // R3 start register width, R7 control field readback
    wr(START, 32'hFF); rd(START, v); chk("R3", "start unused bits", v, 32'h7);
    wr(START, 32'h0);  rd(START, v); chk("R3", "start clear", v, 0);
    wr(ra(2,8), 32'hFFFF); rd(ra(2,8), v); chk("R7", "ctrl unused/flag1", v, 32'h27);
    chk("R7", "irq2 low", 32'(irq[2]), 0);

    // R4/R5/R6 sweep over all prescale codes on channel 0
    for (int code = 0; code < 8; code++) begin
      int dv;
      logic [31:0] c0, r0, cw;
      dv = (code <= 4) ? (4 << (2*code)) : 1024;
      c0 = 32'(code % 3); r0 = 32'(code + 1);
      cw = 32'(code) | (32'(code & 1) << 5);
      wr(START, 32'h0);
      wr(ra(0,8), cw);
      wr(ra(0,0), r0);
      wr(ra(0,4), c0);
      wr(START, 32'h1);
      repeat (3*dv + 2) @(posedge clk);
      model(c0, r0, 3, ec, euf);
      rd(ra(0,4), v); chk("R4", "sweep count", v, ec);
      rd(ra(0,8), v); chk("R5", "sweep ctrl", v, cw | (32'(euf) << 8));
      chk("R6", "sweep irq", 32'(irq[0]), 32'(euf & cw[5]));
    end
    wr(START, 32'h0);

    // R8 prescaler restart, R3 independence on channel 1
    wr(ra(1,8), 32'h1);
    wr(ra(1,4), 32'd100);
    wr(START, 32'h2);
    repeat (15) @(posedge clk);
    rd(ra(1,4), v); chk("R8", "no tick before 16", v, 32'd100);
    @(posedge clk);
    rd(ra(1,4), v); chk("R8", "tick at 16", v, 32'd99);
    repeat (10) @(posedge clk);
    wr(START, 32'h0);
    wr(START, 32'h2);
    repeat (15) @(posedge clk);
    rd(ra(1,4), v); chk("R8", "restart no early tick", v, 32'd99);
    @(posedge clk);
    rd(ra(1,4), v); chk("R8", "restart tick", v, 32'd98);
    rd(ra(2,4), v); chk("R3", "stopped ch2 holds", v, 32'h20000002);
    wr(START, 32'h0);

    // R9 clear coinciding with underflow, R7 clear
    wr(ra(0,8), 32'h0);
    wr(ra(0,0), 32'd5);
    wr(ra(0,4), 32'd0);
    wr(START, 32'h1);
    repeat (19) @(posedge clk);
    wr(ra(0,8), 32'h20);
    rd(ra(0,8), v); chk("R7", "flag cleared", v, 32'h20);
    rd(ra(0,4), v); chk("R5", "count after 5 ticks", v, 32'd1);
    repeat (7) @(posedge clk);
    wr(ra(0,8), 32'h20);
    rd(ra(0,8), v); chk("R9", "set wins over clear", v, 32'h120);
    rd(ra(0,4), v); chk("R5", "reloaded", v, 32'd5);
    chk("R6", "irq on", 32'(irq[0]), 1);
    wr(ra(0,8), 32'h100);
    chk("R6", "irq masked", 32'(irq[0]), 0);
    rd(ra(0,8), v); chk("R6", "flag kept", v, 32'h100);
    wr(ra(0,8), 32'h120);
    chk("R6", "irq back", 32'(irq[0]), 1);

    // R10 counter write on a tick edge
    wr(START, 32'h0);
    wr(START, 32'h1);
    repeat (3) @(posedge clk);
    wr(ra(0,4), 32'h1234);
    rd(ra(0,4), v); chk("R10", "write beats tick", v, 32'h1234);
    wr(START, 32'h0);
    chk("R2", "alt irq idle", 32'(alt_irq), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule